// File: doc/BRIEF.md
# Dual-Bank Processor Register File

This block is the architectural register store of a small 8-bit processor core. It holds an accumulator and a flag byte, six general bytes that group into three 16-bit pairs, two 16-bit index registers, an interrupt-page byte and a refresh counter. The accumulator/flag pair and the three general pairs each have a hidden second bank. Software never addresses that bank directly. It reaches it only through two exchange strobes: one swaps the accumulator/flag pair alone, and the other swaps all three general pairs together. Each swap flips a bank-select bit. No data is copied.

A single select code picks a register for the read port and for the write port. The code can name a byte (any general register, either half of an index register, the page byte or the refresh counter) or a whole 16-bit pair. Reads are registered and appear one clock after the select is presented. The refresh counter advances on every opcode-fetch pulse, including prefix fetches. The block also forms the vectored-interrupt table address from the page byte and the byte that the interrupting device supplies, and drives it out continuously.

Top module: `dual_bank_regfile`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears every register in both banks, the page byte, the refresh counter and both bank selects, and drives rd_data and vec_addr to zero.
- R2: Byte select codes are A=0, F=1, B=2, C=3, D=4, E=5, H=6, L=7, IXH=8, IXL=9, IYH=10, IYL=11, I=12, R=13. A byte write stores wr_data[7:0]. A byte read returns the byte in rd_data[7:0] with rd_data[15:8]=0. rd_data shows the state that was present at the rising edge where rd_sel was sampled.
- R3: Pair codes are AF=16, BC=17, DE=18, HL=19. The first-named register is the high byte, and pair and byte accesses reach the same storage.
- R4: Index codes IX=20 and IY=21 access the whole 16-bit register. The byte codes 8 to 11 access the high and low halves of the same storage.
- R5: An xchg_af pulse swaps the active A/F with their shadow copies and leaves B, C, D, E, H and L unchanged.
- R6: An xchg_main pulse swaps B/C, D/E and H/L with their shadows all at once and leaves A and F unchanged.
- R7: A write in the same cycle as an exchange lands in the bank that was active before the swap.
- R8: An opfetch pulse increments R[6:0] modulo 128, so 0x7F becomes 0x00. R[7] keeps its value.
- R9: A write to R in the same cycle as opfetch takes priority: R takes the written value and does not increment.
- R10: One clock after each rising edge, vec_addr equals {I, int_byte} as they were at that edge.
- R11: Select codes 14, 15 and 22 to 31 are unused. A read returns 0 and a write changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel | input | 5 | Read select code |
| rd_data | output | 16 | Registered read data |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 5 | Write select code |
| wr_data | input | 16 | Write data (low byte for byte codes) |
| xchg_af | input | 1 | Swap the accumulator/flag bank |
| xchg_main | input | 1 | Swap the BC/DE/HL bank |
| opfetch | input | 1 | Opcode-fetch pulse, advances R |
| int_byte | input | 8 | Low byte supplied by the interrupting device |
| vec_addr | output | 16 | Vectored-interrupt table address |

## Verification
The hardest case to reach is a write that coincides with an exchange. Seen from the ports, it lands in a bank that is no longer visible. The stimulus raises the write and the swap strobe in the same cycle. It then reads the register and expects the shadow contents, swaps back, and expects the written value. The banks are first loaded with distinct values so the two outcomes cannot be confused. The refresh counter is driven across its 7-bit wrap with bit 7 set and with bit 7 clear, and one cycle combines a write to R with a fetch pulse.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int SEL_W = 5;

  localparam logic [SEL_W-1:0] SEL_A   = 5'd0;
  localparam logic [SEL_W-1:0] SEL_F   = 5'd1;
  localparam logic [SEL_W-1:0] SEL_B   = 5'd2;
  localparam logic [SEL_W-1:0] SEL_C   = 5'd3;
  localparam logic [SEL_W-1:0] SEL_D   = 5'd4;
  localparam logic [SEL_W-1:0] SEL_E   = 5'd5;
  localparam logic [SEL_W-1:0] SEL_H   = 5'd6;
  localparam logic [SEL_W-1:0] SEL_L   = 5'd7;
  localparam logic [SEL_W-1:0] SEL_IXH = 5'd8;
  localparam logic [SEL_W-1:0] SEL_IXL = 5'd9;
  localparam logic [SEL_W-1:0] SEL_IYH = 5'd10;
  localparam logic [SEL_W-1:0] SEL_IYL = 5'd11;
  localparam logic [SEL_W-1:0] SEL_I   = 5'd12;
  localparam logic [SEL_W-1:0] SEL_R   = 5'd13;
  localparam logic [SEL_W-1:0] SEL_AF  = 5'd16;
  localparam logic [SEL_W-1:0] SEL_BC  = 5'd17;
  localparam logic [SEL_W-1:0] SEL_DE  = 5'd18;
  localparam logic [SEL_W-1:0] SEL_HL  = 5'd19;
  localparam logic [SEL_W-1:0] SEL_IX  = 5'd20;
  localparam logic [SEL_W-1:0] SEL_IY  = 5'd21;

  function automatic logic sel_valid(input logic [SEL_W-1:0] s);
    return (s <= SEL_R) || ((s >= SEL_AF) && (s <= SEL_IY));
  endfunction

  function automatic logic sel_is_pair(input logic [SEL_W-1:0] s);
    return (s >= SEL_AF) && (s <= SEL_IY);
  endfunction
endpackage

// File: rtl/rf_bank_group.sv
module rf_bank_group #(
  parameter int DW     = 8,
  parameter int NPAIRS = 3,
  localparam int PW    = 2 * DW,
  localparam int IDXW  = (NPAIRS > 1) ? $clog2(NPAIRS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 xchg,
  input  logic [IDXW-1:0]      wr_idx,
  input  logic                 wr_hi,
  input  logic                 wr_lo,
  input  logic [PW-1:0]        wr_data,
  output logic [NPAIRS*PW-1:0] act_o,
  output logic                 bank_o
);
  logic bank_q;

  always_ff @(posedge clk) begin
    if (rst) bank_q <= 1'b0;
    else if (xchg) bank_q <= ~bank_q;
  end

  assign bank_o = bank_q;

  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    logic [PW-1:0] slot0_q, slot1_q;
    logic          hit;

    assign hit = (wr_idx == IDXW'(p));

    always_ff @(posedge clk) begin
      if (rst) begin
        slot0_q <= '0;
        slot1_q <= '0;
      end else begin
        if (hit && !bank_q) begin
          if (wr_hi) slot0_q[PW-1:DW] <= wr_data[PW-1:DW];
          if (wr_lo) slot0_q[DW-1:0]  <= wr_data[DW-1:0];
        end
        if (hit && bank_q) begin
          if (wr_hi) slot1_q[PW-1:DW] <= wr_data[PW-1:DW];
          if (wr_lo) slot1_q[DW-1:0]  <= wr_data[DW-1:0];
        end
      end
    end

    assign act_o[p*PW +: PW] = bank_q ? slot1_q : slot0_q;
  end
endmodule

// File: rtl/rf_index_regs.sv
module rf_index_regs #(
  parameter int DW   = 8,
  parameter int NREG = 2,
  localparam int PW  = 2 * DW,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IDXW-1:0]    wr_idx,
  input  logic               wr_hi,
  input  logic               wr_lo,
  input  logic [PW-1:0]      wr_data,
  output logic [NREG*PW-1:0] val_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_idx
    logic [PW-1:0] reg_q;
    logic          hit;

    assign hit = (wr_idx == IDXW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        reg_q <= '0;
      end else if (hit) begin
        if (wr_hi) reg_q[PW-1:DW] <= wr_data[PW-1:DW];
        if (wr_lo) reg_q[DW-1:0]  <= wr_data[DW-1:0];
      end
    end

    assign val_o[g*PW +: PW] = reg_q;
  end
endmodule

// File: rtl/rf_ctrl_regs.sv
module rf_ctrl_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_page,
  input  logic          wr_rfsh,
  input  logic [DW-1:0] wr_byte,
  input  logic          opfetch,
  output logic [DW-1:0] page_o,
  output logic [DW-1:0] rfsh_o
);
  localparam logic [DW-2:0] CNT_ONE = {{(DW-2){1'b0}}, 1'b1};

  logic [DW-1:0] page_q, rfsh_q;

  always_ff @(posedge clk) begin
    if (rst) page_q <= '0;
    else if (wr_page) page_q <= wr_byte;
  end

  // A write has priority over the fetch increment; only the low bits count.
  always_ff @(posedge clk) begin
    if (rst) rfsh_q <= '0;
    else if (wr_rfsh) rfsh_q <= wr_byte;
    else if (opfetch) rfsh_q <= {rfsh_q[DW-1], rfsh_q[DW-2:0] + CNT_ONE};
  end

  assign page_o = page_q;
  assign rfsh_o = rfsh_q;
endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile
  import regbank_pkg::*;
#(
  parameter int DW = 8,
  localparam int PW = 2 * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [PW-1:0]    rd_data,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [PW-1:0]    wr_data,
  input  logic             xchg_af,
  input  logic             xchg_main,
  input  logic             opfetch,
  input  logic [DW-1:0]    int_byte,
  output logic [PW-1:0]    vec_addr
);
  localparam int NMAIN = 3;
  localparam int NIDX  = 2;
  localparam int MIW   = $clog2(NMAIN);
  localparam int IIW   = (NIDX > 1) ? $clog2(NIDX) : 1;
  localparam logic [DW-1:0] ZB = '0;

  logic [PW-1:0]       grp_data;
  logic                af_hi, af_lo;
  logic [MIW-1:0]      mn_idx;
  logic                mn_hi, mn_lo;
  logic [IIW-1:0]      ix_idx;
  logic                ix_hi, ix_lo;
  logic                wr_page, wr_rfsh;

  logic [PW-1:0]       af_act;
  logic [NMAIN*PW-1:0] mn_act;
  logic [NIDX*PW-1:0]  ix_act;
  logic                af_bank, mn_bank;
  logic [DW-1:0]       i_val, r_val;
  logic [PW-1:0]       bc_v, de_v, hl_v, ix_v, iy_v;
  logic [PW-1:0]       rd_next;
  logic [PW-1:0]       rd_q, vec_q;

  // Byte writes replicate the byte so either half-enable picks it up.
  assign grp_data = sel_is_pair(wr_sel) ? wr_data : {wr_data[DW-1:0], wr_data[DW-1:0]};

  always_comb begin
    af_hi = 1'b0; af_lo = 1'b0;
    mn_idx = '0;  mn_hi = 1'b0; mn_lo = 1'b0;
    ix_idx = '0;  ix_hi = 1'b0; ix_lo = 1'b0;
    wr_page = 1'b0; wr_rfsh = 1'b0;
    if (wr_en) begin
      case (wr_sel)
        SEL_A:   af_hi = 1'b1;
        SEL_F:   af_lo = 1'b1;
        SEL_AF:  begin af_hi = 1'b1; af_lo = 1'b1; end
        SEL_B:   begin mn_idx = MIW'(0); mn_hi = 1'b1; end
        SEL_C:   begin mn_idx = MIW'(0); mn_lo = 1'b1; end
        SEL_BC:  begin mn_idx = MIW'(0); mn_hi = 1'b1; mn_lo = 1'b1; end
        SEL_D:   begin mn_idx = MIW'(1); mn_hi = 1'b1; end
        SEL_E:   begin mn_idx = MIW'(1); mn_lo = 1'b1; end
        SEL_DE:  begin mn_idx = MIW'(1); mn_hi = 1'b1; mn_lo = 1'b1; end
        SEL_H:   begin mn_idx = MIW'(2); mn_hi = 1'b1; end
        SEL_L:   begin mn_idx = MIW'(2); mn_lo = 1'b1; end
        SEL_HL:  begin mn_idx = MIW'(2); mn_hi = 1'b1; mn_lo = 1'b1; end
        SEL_IXH: begin ix_idx = IIW'(0); ix_hi = 1'b1; end
        SEL_IXL: begin ix_idx = IIW'(0); ix_lo = 1'b1; end
        SEL_IX:  begin ix_idx = IIW'(0); ix_hi = 1'b1; ix_lo = 1'b1; end
        SEL_IYH: begin ix_idx = IIW'(1); ix_hi = 1'b1; end
        SEL_IYL: begin ix_idx = IIW'(1); ix_lo = 1'b1; end
        SEL_IY:  begin ix_idx = IIW'(1); ix_hi = 1'b1; ix_lo = 1'b1; end
        SEL_I:   wr_page = 1'b1;
        SEL_R:   wr_rfsh = 1'b1;
        default: ;
      endcase
    end
  end

  rf_bank_group #(.DW(DW), .NPAIRS(1)) u_af_bank (
    .clk     (clk),
    .rst     (rst),
    .xchg    (xchg_af),
    .wr_idx  (1'b0),
    .wr_hi   (af_hi),
    .wr_lo   (af_lo),
    .wr_data (grp_data),
    .act_o   (af_act),
    .bank_o  (af_bank)
  );

  rf_bank_group #(.DW(DW), .NPAIRS(NMAIN)) u_main_bank (
    .clk     (clk),
    .rst     (rst),
    .xchg    (xchg_main),
    .wr_idx  (mn_idx),
    .wr_hi   (mn_hi),
    .wr_lo   (mn_lo),
    .wr_data (grp_data),
    .act_o   (mn_act),
    .bank_o  (mn_bank)
  );

  rf_index_regs #(.DW(DW), .NREG(NIDX)) u_index (
    .clk     (clk),
    .rst     (rst),
    .wr_idx  (ix_idx),
    .wr_hi   (ix_hi),
    .wr_lo   (ix_lo),
    .wr_data (grp_data),
    .val_o   (ix_act)
  );

  rf_ctrl_regs #(.DW(DW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_page (wr_page),
    .wr_rfsh (wr_rfsh),
    .wr_byte (wr_data[DW-1:0]),
    .opfetch (opfetch),
    .page_o  (i_val),
    .rfsh_o  (r_val)
  );

  assign bc_v = mn_act[0*PW +: PW];
  assign de_v = mn_act[1*PW +: PW];
  assign hl_v = mn_act[2*PW +: PW];
  assign ix_v = ix_act[0*PW +: PW];
  assign iy_v = ix_act[1*PW +: PW];

  always_comb begin
    case (rd_sel)
      SEL_A:   rd_next = {ZB, af_act[PW-1:DW]};
      SEL_F:   rd_next = {ZB, af_act[DW-1:0]};
      SEL_B:   rd_next = {ZB, bc_v[PW-1:DW]};
      SEL_C:   rd_next = {ZB, bc_v[DW-1:0]};
      SEL_D:   rd_next = {ZB, de_v[PW-1:DW]};
      SEL_E:   rd_next = {ZB, de_v[DW-1:0]};
      SEL_H:   rd_next = {ZB, hl_v[PW-1:DW]};
      SEL_L:   rd_next = {ZB, hl_v[DW-1:0]};
      SEL_IXH: rd_next = {ZB, ix_v[PW-1:DW]};
      SEL_IXL: rd_next = {ZB, ix_v[DW-1:0]};
      SEL_IYH: rd_next = {ZB, iy_v[PW-1:DW]};
      SEL_IYL: rd_next = {ZB, iy_v[DW-1:0]};
      SEL_I:   rd_next = {ZB, i_val};
      SEL_R:   rd_next = {ZB, r_val};
      SEL_AF:  rd_next = af_act;
      SEL_BC:  rd_next = bc_v;
      SEL_DE:  rd_next = de_v;
      SEL_HL:  rd_next = hl_v;
      SEL_IX:  rd_next = ix_v;
      SEL_IY:  rd_next = iy_v;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      vec_q <= '0;
    end else begin
      rd_q  <= rd_next;
      vec_q <= {i_val, int_byte};
    end
  end

  assign rd_data  = rd_q;
  assign vec_addr = vec_q;
endmodule

// File: rtl/dual_bank_regfile_chk.sv
module dual_bank_regfile_chk
  import regbank_pkg::*;
#(
  parameter int DW = 8,
  localparam int PW = 2 * DW
) (
  input logic             clk,
  input logic             rst,
  input logic [SEL_W-1:0] rd_sel,
  input logic [PW-1:0]    rd_data,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_sel,
  input logic [PW-1:0]    wr_data,
  input logic             xchg_af,
  input logic             xchg_main,
  input logic             opfetch,
  input logic [DW-1:0]    int_byte,
  input logic [PW-1:0]    vec_addr,
  input logic             af_bank,
  input logic             mn_bank,
  input logic [DW-1:0]    i_val,
  input logic [DW-1:0]    r_val
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && vec_addr == '0 && i_val == '0 && r_val == '0 && !af_bank && !mn_bank));

  // R5
  af_swap_chk: assert property (@(posedge clk) disable iff (rst)
    xchg_af |=> (af_bank != $past(af_bank)));

  // R5
  af_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !xchg_af |=> $stable(af_bank));

  // R6
  main_swap_chk: assert property (@(posedge clk) disable iff (rst)
    xchg_main |=> (mn_bank != $past(mn_bank)));

  // R8
  rfsh_count_chk: assert property (@(posedge clk) disable iff (rst)
    (opfetch && !(wr_en && wr_sel == SEL_R)) |=>
      (r_val[DW-2:0] == $past(r_val[DW-2:0]) + 1'b1) && (r_val[DW-1] == $past(r_val[DW-1])));

  // R9
  rfsh_write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_R) |=> (r_val == $past(wr_data[DW-1:0])));

  // R10
  vector_addr_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (vec_addr == {$past(i_val), $past(int_byte)}));

  // R11
  unused_read_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_valid(rd_sel) |=> (rd_data == '0));
endmodule

bind dual_bank_regfile dual_bank_regfile_chk #(.DW(DW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .rd_sel    (rd_sel),
  .rd_data   (rd_data),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .xchg_af   (xchg_af),
  .xchg_main (xchg_main),
  .opfetch   (opfetch),
  .int_byte  (int_byte),
  .vec_addr  (vec_addr),
  .af_bank   (af_bank),
  .mn_bank   (mn_bank),
  .i_val     (i_val),
  .r_val     (r_val)
);

// File: tb/dual_bank_regfile_tb_top.sv
`timescale 1ns/1ps
module dual_bank_regfile_tb_top;
  localparam realtime HALF = 4ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        xchg_af = 1'b0;
  logic        xchg_main = 1'b0;
  logic        opfetch = 1'b0;
  logic [7:0]  int_byte = '0;
  logic [15:0] vec_addr;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #(HALF) clk = ~clk;

  dual_bank_regfile dut_i (
    .clk       (clk),
    .rst       (rst),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .xchg_af   (xchg_af),
    .xchg_main (xchg_main),
    .opfetch   (opfetch),
    .int_byte  (int_byte),
    .vec_addr  (vec_addr)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] s, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] s, input logic [15:0] exp);
    @(negedge clk);
    rd_sel = s;
    @(negedge clk);
    chk(req, rd_data, exp);
  endtask

  task automatic pulse_af();
    @(negedge clk); xchg_af = 1'b1;
    @(negedge clk); xchg_af = 1'b0;
  endtask

  task automatic pulse_main();
    @(negedge clk); xchg_main = 1'b1;
    @(negedge clk); xchg_main = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rd_data after reset", rd_data, 16'h0000);
    chk("R1 vec_addr after reset", vec_addr, 16'h0000);
    rd_chk("R1 AF after reset", 5'd16, 16'h0000);
    rd_chk("R1 R after reset", 5'd13, 16'h0000);
    rd_chk("R1 I after reset", 5'd12, 16'h0000);
  endtask

  task automatic t_bytes_pairs();
    wr(5'd2, 16'hFF12);
    wr(5'd3, 16'h0034);
    rd_chk("R2 B byte zero-extended", 5'd2, 16'h0012);
    rd_chk("R3 BC pair high=B", 5'd17, 16'h1234);
    wr(5'd19, 16'hBEEF);
    rd_chk("R3 H from HL", 5'd6, 16'h00BE);
    rd_chk("R3 L from HL", 5'd7, 16'h00EF);
    wr(5'd18, 16'hD0E0);
    rd_chk("R2 E byte", 5'd5, 16'h00E0);
  endtask

  task automatic t_index();
    wr(5'd20, 16'hA1B2);
    wr(5'd21, 16'h5A6B);
    wr(5'd9, 16'h00CC);
    rd_chk("R4 IX after IXL write", 5'd20, 16'hA1CC);
    rd_chk("R4 IYH half", 5'd10, 16'h005A);
    rd_chk("R4 IY whole", 5'd21, 16'h5A6B);
  endtask

  task automatic t_af_swap();
    wr(5'd0, 16'h0011);
    wr(5'd1, 16'h0022);
    pulse_af();
    rd_chk("R5 shadow AF empty", 5'd16, 16'h0000);
    rd_chk("R5 BC untouched by AF swap", 5'd17, 16'h1234);
    wr(5'd16, 16'h3344);
    pulse_af();
    rd_chk("R5 AF restored", 5'd16, 16'h1122);
  endtask

  task automatic t_main_swap();
    pulse_main();
    rd_chk("R6 shadow BC empty", 5'd17, 16'h0000);
    rd_chk("R6 shadow HL empty", 5'd19, 16'h0000);
    rd_chk("R6 AF untouched by main swap", 5'd16, 16'h1122);
    wr(5'd18, 16'h5566);
    pulse_main();
    rd_chk("R6 DE restored", 5'd18, 16'hD0E0);
    rd_chk("R6 BC restored", 5'd17, 16'h1234);
    pulse_main();
    rd_chk("R6 shadow DE kept", 5'd18, 16'h5566);
    pulse_main();
  endtask

  task automatic t_write_during_swap();
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 5'd0; wr_data = 16'h0077; xchg_af = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; xchg_af = 1'b0;
    rd_chk("R7 A after swap shows shadow", 5'd0, 16'h0033);
    pulse_af();
    rd_chk("R7 write landed in old bank", 5'd16, 16'h7722);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 5'd17; wr_data = 16'h9988; xchg_main = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; xchg_main = 1'b0;
    rd_chk("R7 BC after main swap shows shadow", 5'd17, 16'h0000);
    pulse_main();
    rd_chk("R7 BC write in old bank", 5'd17, 16'h9988);
  endtask

  task automatic t_refresh();
    wr(5'd13, 16'h00FE);
    @(negedge clk); opfetch = 1'b1;
    repeat (3) @(negedge clk);
    opfetch = 1'b0;
    rd_chk("R8 wrap keeps bit7", 5'd13, 16'h0081);
    wr(5'd13, 16'h007F);
    @(negedge clk); opfetch = 1'b1;
    @(negedge clk); opfetch = 1'b0;
    rd_chk("R8 wrap to zero", 5'd13, 16'h0000);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 5'd13; wr_data = 16'h0005; opfetch = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; opfetch = 1'b0;
    rd_chk("R9 write beats fetch", 5'd13, 16'h0005);
    @(negedge clk); opfetch = 1'b1;
    @(negedge clk); opfetch = 1'b0;
    rd_chk("R8 single increment", 5'd13, 16'h0006);
  endtask

  task automatic t_vector();
    wr(5'd12, 16'h003C);
    @(negedge clk); int_byte = 8'hA5;
    @(negedge clk);
    chk("R10 vector address", vec_addr, 16'h3CA5);
    @(negedge clk); int_byte = 8'h01;
    @(negedge clk);
    chk("R10 vector follows device byte", vec_addr, 16'h3C01);
  endtask

  task automatic t_unused();
    wr(5'd14, 16'h00AB);
    wr(5'd22, 16'hCDEF);
    wr(5'd31, 16'h1357);
    rd_chk("R11 read unused 22", 5'd22, 16'h0000);
    rd_chk("R11 read unused 15", 5'd15, 16'h0000);
    rd_chk("R11 AF not written", 5'd16, 16'h7722);
    rd_chk("R11 BC not written", 5'd17, 16'h9988);
    rd_chk("R11 IY not written", 5'd21, 16'h5A6B);
    rd_chk("R11 I not written", 5'd12, 16'h003C);
  endtask

  task automatic t_mid_reset();
    pulse_af();
    do_reset();
    @(negedge clk);
    chk("R1 vector after reset", vec_addr, 16'h0001);
    rd_chk("R1 A cleared", 5'd0, 16'h0000);
    rd_chk("R1 BC cleared", 5'd17, 16'h0000);
    rd_chk("R1 I cleared", 5'd12, 16'h0000);
    rd_chk("R1 R cleared", 5'd13, 16'h0000);
    pulse_af();
    rd_chk("R1 shadow AF cleared", 5'd16, 16'h0000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_bytes_pairs();
    t_index();
    t_af_swap();
    t_main_swap();
    t_write_during_swap();
    t_refresh();
    t_vector();
    t_unused();
    t_mid_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule